// File: doc/BRIEF.md
# Split-Phase Shared Bus Transaction Sequencer

This block pairs a bus master with a small memory slave that talk over one shared set of wires. Each transfer is cut into phases, and a two-bit phase field travels with the word. The phase field marks every cycle as idle, read address, write address or data. Address and data take turns on the same word lines. A load takes three bus cycles: the master sends the read address, the bus stays quiet for one turnaround cycle, and then the slave sends the stored word back, which the master captures. A store takes two bus cycles, both driven by the master. The slave latches the write address from the first cycle and keeps it pending until the data cycle arrives.

A client issues one command at a time through a valid/ready pair. The block answers each finished command with a one-cycle completion pulse. A third command sends a lone data phase with no address in front of it. The slave must reject that phase: it raises an error pulse and leaves storage untouched. The resolved bus is brought out on ports so that an observer can follow every phase.

Top module: `sbus_seq`

## Requirements
- R1: After synchronous active-low reset, `req_ready` is 1, `done` and `bus_err` are 0, and `bus_phase` is 0 (idle).
- R2: In the cycle after a read command (`req_cmd`=0) is accepted, `bus_phase` is 1 (read address) and `bus_word` carries the address, zero-extended.
- R3: The bus is idle (`bus_phase`=0, `bus_word`=0) in the cycle after a read address phase and in the cycle after the slave's data phase, so master and slave never drive in adjacent cycles.
- R4: Two cycles after the read address phase, the slave drives `bus_phase`=3 (data) with the word stored at that address.
- R5: In the cycle after the slave's data phase, `done` is 1 for exactly one cycle and `rd_data` holds the captured word until the next read completes.
- R6: A write command (`req_cmd`=1) puts `bus_phase`=2 (write address) with the address on the bus, then `bus_phase`=3 with the write data in the next cycle; `done` pulses in the cycle after the data phase.
- R7: A word written to an address is returned by a later read of that address, and other addresses keep their contents.
- R8: A lone data command (`req_cmd` with bit 1 set) drives one data phase with no pending write address; the slave raises `bus_err` for one cycle right after it, storage is unchanged, and `done` still pulses.
- R9: While a command is in flight `req_ready` is 0 and a request presented then is ignored.
- R10: The master and the slave never drive the bus in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Command present |
| req_cmd | input | 2 | 0 read, 1 write, 2 or 3 lone data phase |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Store data |
| req_ready | output | 1 | Master idle, command accepted this cycle if valid |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DW | Last word captured by a read |
| bus_err | output | 1 | One-cycle pulse: data phase without pending write address |
| bus_phase | output | 2 | Resolved bus phase field |
| bus_word | output | DW | Resolved bus word lines |

## Verification
The bench builds the block with its defaults, 4 address bits and 16 data bits. The whole 16-word store is therefore reachable, and the lowest and highest addresses, as well as all-zero and all-one data words, can be exercised directly. Phase-by-phase sampling after each accepted command checks the turnaround gaps, the ordering of the write phases and the timing of the completion pulse. A request held during a read tests that commands presented while busy are dropped, and a lone data phase tests rejection by the slave and that storage is left untouched.

// File: rtl/sbus_pkg.sv
// Shared definitions for the split-phase bus: phase field codes and command codes.
package sbus_pkg;
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_ADDR_RD = 2'd1,
        PH_ADDR_WR = 2'd2,
        PH_DATA    = 2'd3
    } phase_t;

    localparam logic [1:0] CMD_READ  = 2'd0;
    localparam logic [1:0] CMD_WRITE = 2'd1;
endpackage

// File: rtl/sbus_master.sv
// Bus master: takes one command at a time and walks it through its bus phases.
// Assumes the slave answers a read address exactly two cycles later (one idle
// turnaround cycle, then its data cycle) and that DW >= AW.
module sbus_master
    import sbus_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_cmd,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          done,
    output logic [DW-1:0] rd_data,
    input  logic [DW-1:0] bus_word,
    output logic          m_oe,
    output phase_t        m_phase,
    output logic [DW-1:0] m_word
);
    typedef enum logic [2:0] {M_IDLE, M_ADDR, M_TURN, M_CAP, M_GAP, M_DATA} mstate_t;

    mstate_t       state;
    logic          is_rd;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;

    assign req_ready = (state == M_IDLE);

    // Drive the bus only in the master's own phases.
    always_comb begin
        m_oe    = 1'b0;
        m_phase = PH_IDLE;
        m_word  = '0;
        case (state)
            M_ADDR: begin
                m_oe    = 1'b1;
                m_phase = is_rd ? PH_ADDR_RD : PH_ADDR_WR;
                m_word  = DW'(addr_q);
            end
            M_DATA: begin
                m_oe    = 1'b1;
                m_phase = PH_DATA;
                m_word  = wdata_q;
            end
            default: ;
        endcase
    end

    // Phase sequencing, data capture and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= M_IDLE;
            is_rd   <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rd_data <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                M_IDLE: if (req_valid) begin
                    addr_q  <= req_addr;
                    wdata_q <= req_wdata;
                    is_rd   <= (req_cmd == CMD_READ);
                    state   <= req_cmd[1] ? M_DATA : M_ADDR;
                end
                M_ADDR: state <= is_rd ? M_TURN : M_DATA;
                M_TURN: state <= M_CAP;
                M_CAP: begin
                    rd_data <= bus_word;
                    done    <= 1'b1;
                    state   <= M_GAP;
                end
                M_GAP: state <= M_IDLE;
                M_DATA: begin
                    done  <= 1'b1;
                    state <= M_IDLE;
                end
                default: state <= M_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sbus_mem.sv
// Word storage behind the slave: asynchronous read, synchronous write.
// Assumes contents are undefined until written; no reset on the array.
module sbus_mem #(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    // Store one word when the slave commits a write.
    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/sbus_slave.sv
// Memory slave: decodes bus phases, holds a latched write address until its
// data phase, answers reads after one turnaround cycle and flags stray data.
// Assumes it never decodes the bus while it is itself driving a reply.
module sbus_slave
    import sbus_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_t        bus_phase,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_word,
    output logic          s_oe,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          bus_err
);
    typedef enum logic [1:0] {S_IDLE, S_TURN, S_DRIVE} sstate_t;

    sstate_t       state;
    logic          pend;
    logic [AW-1:0] addr_q;

    assign s_oe      = (state == S_DRIVE);
    assign mem_addr  = addr_q;
    assign mem_wdata = bus_word;
    assign mem_we    = (state == S_IDLE) && (bus_phase == PH_DATA) && pend;

    // Phase decode, pending write address and stray-data flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            pend    <= 1'b0;
            addr_q  <= '0;
            bus_err <= 1'b0;
        end else begin
            bus_err <= 1'b0;
            case (state)
                S_IDLE: begin
                    case (bus_phase)
                        PH_ADDR_RD: begin
                            addr_q <= bus_addr;
                            state  <= S_TURN;
                        end
                        PH_ADDR_WR: begin
                            addr_q <= bus_addr;
                            pend   <= 1'b1;
                        end
                        PH_DATA: begin
                            if (pend) pend    <= 1'b0;
                            else      bus_err <= 1'b1;
                        end
                        default: ;
                    endcase
                end
                S_TURN:  state <= S_DRIVE;
                S_DRIVE: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sbus_seq.sv
// Top: master and memory slave joined by one resolved shared bus.
// The bus is modelled as a driver-select mux; when nobody drives it reads idle/zero.
// Assumes DW >= AW so an address fits on the word lines.
module sbus_seq
    import sbus_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_cmd,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          done,
    output logic [DW-1:0] rd_data,
    output logic          bus_err,
    output logic [1:0]    bus_phase,
    output logic [DW-1:0] bus_word
);
    logic          m_oe;
    phase_t        m_phase;
    logic [DW-1:0] m_word;
    logic          s_oe;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    phase_t        bus_ph;

    // Resolve who owns the shared wires this cycle.
    always_comb begin
        if (m_oe) begin
            bus_ph   = m_phase;
            bus_word = m_word;
        end else if (s_oe) begin
            bus_ph   = PH_DATA;
            bus_word = mem_rdata;
        end else begin
            bus_ph   = PH_IDLE;
            bus_word = '0;
        end
    end

    assign bus_phase = bus_ph;

    sbus_master #(.AW(AW), .DW(DW)) u_master (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .done(done),
        .rd_data(rd_data), .bus_word(bus_word),
        .m_oe(m_oe), .m_phase(m_phase), .m_word(m_word)
    );

    sbus_slave #(.AW(AW), .DW(DW)) u_slave (
        .clk(clk), .rst_n(rst_n),
        .bus_phase(bus_ph), .bus_addr(bus_word[AW-1:0]), .bus_word(bus_word),
        .s_oe(s_oe), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .bus_err(bus_err)
    );

    sbus_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
        .raddr(mem_addr), .rdata(mem_rdata)
    );
endmodule

// File: rtl/sbus_seq_chk.sv
// Checker for sbus_seq: bus ownership, phase ordering and pulse widths.
module sbus_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       m_oe,
    input logic       s_oe,
    input logic [1:0] bus_phase,
    input logic       done,
    input logic       bus_err
);
    // R10
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_oe && s_oe));

    // R3
    rd_turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_phase == 2'd1) |=> (bus_phase == 2'd0));

    // R4
    slave_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_phase == 2'd1) |=> ##1 (bus_phase == 2'd3 && s_oe));

    // R6
    wr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_phase == 2'd2) |=> (bus_phase == 2'd3 && m_oe));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_err) |-> $past(bus_phase == 2'd3));
endmodule

bind sbus_seq sbus_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .m_oe(m_oe), .s_oe(s_oe),
    .bus_phase(bus_phase), .done(done), .bus_err(bus_err)
);

// File: tb/sbus_seq_bench.sv
`timescale 1ns/1ps
module sbus_seq_bench;
    localparam int AW = 4;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_cmd = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready;
    logic          done;
    logic [DW-1:0] rd_data;
    logic          bus_err;
    logic [1:0]    bus_phase;
    logic [DW-1:0] bus_word;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sbus_seq #(.AW(AW), .DW(DW)) u_sbus_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .done(done), .rd_data(rd_data), .bus_err(bus_err),
        .bus_phase(bus_phase), .bus_word(bus_word)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present one command at a negedge; it is accepted at the next posedge.
    task automatic issue(input logic [1:0] cmd, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_cmd = cmd; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 ready", 32'(req_ready), 1);
        chk("R1 done", 32'(done), 0);
        chk("R1 err", 32'(bus_err), 0);
        chk("R1 phase", 32'(bus_phase), 0);
    endtask

    task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        issue(2'd1, a, d);
        chk("R6 waddr phase", 32'(bus_phase), 2);
        chk("R6 waddr word", 32'(bus_word), 32'(a));
        @(negedge clk);
        chk("R6 wdata phase", 32'(bus_phase), 3);
        chk("R6 wdata word", 32'(bus_word), 32'(d));
        chk("R6 no early done", 32'(done), 0);
        @(negedge clk);
        chk("R6 done", 32'(done), 1);
        chk("R8 no err on write", 32'(bus_err), 0);
    endtask

    task automatic t_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
        issue(2'd0, a, '0);
        chk("R2 raddr phase", 32'(bus_phase), 1);
        chk("R2 raddr word", 32'(bus_word), 32'(a));
        chk("R9 busy", 32'(req_ready), 0);
        @(negedge clk);
        chk("R3 gap phase", 32'(bus_phase), 0);
        chk("R3 gap word", 32'(bus_word), 0);
        @(negedge clk);
        chk("R4 reply phase", 32'(bus_phase), 3);
        chk("R4/R7 reply word", 32'(bus_word), 32'(exp));
        @(negedge clk);
        chk("R5 done", 32'(done), 1);
        chk("R5/R7 rd_data", 32'(rd_data), 32'(exp));
        chk("R3 trailing gap", 32'(bus_phase), 0);
        @(negedge clk);
        chk("R5 done one cycle", 32'(done), 0);
        chk("R5 rd_data held", 32'(rd_data), 32'(exp));
    endtask

    task automatic t_stray(input logic [DW-1:0] d);
        issue(2'd2, 4'd7, d);
        chk("R8 data phase", 32'(bus_phase), 3);
        chk("R8 data word", 32'(bus_word), 32'(d));
        @(negedge clk);
        chk("R8 err", 32'(bus_err), 1);
        chk("R8 done", 32'(done), 1);
        @(negedge clk);
        chk("R8 err one cycle", 32'(bus_err), 0);
    endtask

    // A request held during a read must be dropped.
    task automatic t_busy(input logic [AW-1:0] ra, input logic [AW-1:0] xa);
        issue(2'd0, ra, '0);
        req_valid = 1'b1; req_cmd = 2'd1; req_addr = xa; req_wdata = 16'hDEAD;
        @(negedge clk);
        chk("R9 ready low", 32'(req_ready), 0);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write(4'd0, 16'h0000);
        t_write(4'd15, 16'hFFFF);
        t_write(4'd7, 16'h1234);
        t_write(4'd3, 16'hA5C3);
        t_read(4'd15, 16'hFFFF);
        t_read(4'd0, 16'h0000);
        t_read(4'd7, 16'h1234);
        t_write(4'd3, 16'h5A5A);
        t_read(4'd3, 16'h5A5A);
        t_read(4'd7, 16'h1234);
        t_stray(16'hBEEF);
        t_read(4'd7, 16'h1234);
        t_read(4'd3, 16'h5A5A);
        t_busy(4'd0, 4'd15);
        t_read(4'd15, 16'hFFFF);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule